// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

A single-channel timer behind a small word-addressed register bus. Software writes a start value into two load words, then sets a run bit in the control word. The counter takes that value and decrements once per clock. When it reaches zero it raises a sticky expiry flag. The flag is gated by an interrupt enable onto the `irq` line.

Each run counts in one of two modes. In one-shot mode the timer stops on its own at zero. In periodic mode it refills from the load words and carries on, so a load of all ones makes a free-running tick counter whose complement is the elapsed time. The counter width is chosen at run time: it is either the low 32 bits alone or the full 64 bits.

The live count can be read directly. It can also be read through a shadow copy that trails it by one clock. A read of the low shadow word freezes the upper shadow half, so a 64-bit value can be read as a consistent pair of words.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The word offsets are fixed as follows. 0x00 and 0x04 hold the low and high load words. 0x08 and 0x0C give the low and high live count. 0x10 is control, 0x14 is interrupt, and 0x18 and 0x1C give the low and high shadow count. In the control word, bit 0 selects periodic mode, bit 1 is run and bit 16 selects 64-bit width. All other control bits read 0. Load words read back as written.
- R3: A control write that sets run while the timer is stopped copies the load words into the counter on that clock edge. While running, the counter then decrements by one per clock.
- R4: The raw expiry flag (interrupt word bit 1) is set on the edge where the counter becomes zero. It stays set until software writes the interrupt word with bit 3 set. Bit 3 always reads 0, and a write to bit 1 has no effect.
- R5: Interrupt word bit 0 is the enable. Bit 2 reads as raw flag AND enable, and `irq` equals that same value.
- R6: In one-shot mode (bit 0 = 0) expiry clears the run bit and the counter stays at zero.
- R7: In periodic mode the counter reloads from the load words on the clock after it reaches zero, giving a period of load+1 clocks. With a load of 0 it expires on every clock.
- R8: Load writes made while running do not disturb the current count. The new value is used at the next reload.
- R9: With bit 16 clear, only the low 32 bits count and wrap within 32 bits. The high load word is not used and the high count reads 0.
- R10: With bit 16 set, a borrow out of the low word decrements the high word.
- R11: The shadow count equals the live count of the previous clock. A read of shadow-low with `bus_rd` high freezes the upper shadow half, which the next read of shadow-high returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; word aligned |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe (used only by the shadow latch) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word, same cycle |
| irq | output | 1 | Gated expiry interrupt |

## Verification
Read data is combinational, so each read is compared within the cycle in which the address is driven. A written register shows its new value from the clock after the write strobe. After the edge that takes a run-setting control write, the counter holds the load value and steps once per clock from there. The expiry flag and `irq` rise on the same edge that brings the counter to zero. The shadow words trail the live count by exactly one edge, and the frozen high half is taken on the edge that ends a shadow-low read. The bench drives every access half a clock ahead of the edge and steps a requirement-level model on each edge, so every sampled value is compared in the cycle where that count says it is due.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [2:0] {
      RG_LOAD_LO = 3'd0,
      RG_LOAD_HI = 3'd1,
      RG_CNT_LO  = 3'd2,
      RG_CNT_HI  = 3'd3,
      RG_CTRL    = 3'd4,
      RG_IRQ     = 3'd5,
      RG_SHD_LO  = 3'd6,
      RG_SHD_HI  = 3'd7
   } reg_sel_e;

   localparam int unsigned CTL_PERIODIC_BIT = 0;
   localparam int unsigned CTL_RUN_BIT      = 1;
   localparam int unsigned CTL_WIDE_BIT     = 16;

   localparam int unsigned IRQ_EN_BIT  = 0;
   localparam int unsigned IRQ_RAW_BIT = 1;
   localparam int unsigned IRQ_MSK_BIT = 2;
   localparam int unsigned IRQ_CLR_BIT = 3;

   localparam int unsigned SEL_LSB = 2;
   localparam int unsigned SEL_W   = 3;

endpackage

// File: rtl/evt_timer_cfg.sv
module evt_timer_cfg
   import evt_timer_pkg::*;
#(
   parameter int unsigned HALF_W  = 32,
   parameter bit          WIDE_EN = 1'b1,
   localparam int unsigned CNT_W  = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load_lo,
   input  logic              wr_load_hi,
   input  logic              wr_ctrl,
   input  logic              wr_irq,
   input  logic [HALF_W-1:0] wdata,
   input  logic              expire,
   input  logic              hw_stop,
   output logic [CNT_W-1:0]  load_val,
   output logic              ctl_per,
   output logic              ctl_run,
   output logic              ctl_wide,
   output logic              start,
   output logic              start_wide,
   output logic              irq_en,
   output logic              irq_raw
);

   logic [HALF_W-1:0] load_lo_q;
   logic [HALF_W-1:0] load_hi_q;

   assign start      = wr_ctrl && wdata[CTL_RUN_BIT] && !ctl_run;
   assign start_wide = WIDE_EN && wdata[CTL_WIDE_BIT];
   assign load_val   = {load_hi_q, load_lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_lo_q <= '0;
      end else if (wr_load_lo) begin
         load_lo_q <= wdata;
      end
   end

   generate
      if (WIDE_EN) begin : g_hi_word
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               load_hi_q <= '0;
            end else if (wr_load_hi) begin
               load_hi_q <= wdata;
            end
         end
      end else begin : g_hi_tied
         assign load_hi_q = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_per  <= 1'b0;
         ctl_run  <= 1'b0;
         ctl_wide <= 1'b0;
      end else if (wr_ctrl) begin
         ctl_per  <= wdata[CTL_PERIODIC_BIT];
         ctl_run  <= wdata[CTL_RUN_BIT];
         ctl_wide <= start_wide;
      end else if (hw_stop) begin
         ctl_run  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en  <= 1'b0;
         irq_raw <= 1'b0;
      end else begin
         if (wr_irq) begin
            irq_en <= wdata[IRQ_EN_BIT];
         end
         if (expire) begin
            irq_raw <= 1'b1;
         end else if (wr_irq && wdata[IRQ_CLR_BIT]) begin
            irq_raw <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
   parameter int unsigned HALF_W  = 32,
   parameter bit          WIDE_EN = 1'b1,
   localparam int unsigned CNT_W  = 2 * HALF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wide,
   input  logic             run,
   input  logic             periodic,
   input  logic             wide,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire,
   output logic             hw_stop
);

   localparam logic [CNT_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] run_mask;
   logic [CNT_W-1:0] start_mask;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur;
   logic [CNT_W-1:0] nxt;

   generate
      if (WIDE_EN) begin : g_sel_width
         assign run_mask   = wide       ? '1 : LOW_MASK;
         assign start_mask = start_wide ? '1 : LOW_MASK;
      end else begin : g_low_only
         logic unused_w;
         assign unused_w   = wide ^ start_wide;
         assign run_mask   = LOW_MASK;
         assign start_mask = LOW_MASK;
      end
   endgenerate

   always_comb begin
      cur = cnt_q & run_mask;
      if (cur == '0) begin
         nxt = periodic ? (load_val & run_mask) : '0;
      end else begin
         nxt = (cur - ONE) & run_mask;
      end
   end

   assign expire  = run && (nxt == '0);
   assign hw_stop = expire && !periodic;
   assign cnt     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load_val & start_mask;
      end else if (run) begin
         cnt_q <= nxt;
      end
   end

endmodule

// File: rtl/evt_timer_shadow.sv
module evt_timer_shadow #(
   parameter int unsigned HALF_W = 32,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              latch_hi,
   output logic [CNT_W-1:0]  shd,
   output logic [HALF_W-1:0] hi_held
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd     <= '0;
         hi_held <= '0;
      end else begin
         shd <= cnt;
         if (latch_hi) begin
            hi_held <= shd[CNT_W-1:HALF_W];
         end
      end
   end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter bit          WIDE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned CNT_W    = 2 * DATA_W;
   localparam int unsigned WIN_BITS = SEL_LSB + SEL_W;

   generate
      if (DATA_W <= CTL_WIDE_BIT) begin : g_bad_data_w
         $error("evt_timer: DATA_W must exceed the width-select bit position");
      end
      if (ADDR_W < WIN_BITS) begin : g_bad_addr_w
         $error("evt_timer: ADDR_W too small for the register window");
      end
   endgenerate

   reg_sel_e          sel;
   logic              in_range;
   logic              wr_hit;
   logic [CNT_W-1:0]  load_val;
   logic [CNT_W-1:0]  live_cnt;
   logic [CNT_W-1:0]  shd_cnt;
   logic [DATA_W-1:0] shd_hi_held;
   logic              ctl_per;
   logic              ctl_run;
   logic              ctl_wide;
   logic              start;
   logic              start_wide;
   logic              expire;
   logic              hw_stop;
   logic              irq_en;
   logic              irq_raw;

   assign sel      = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
   assign in_range = (bus_addr[SEL_LSB-1:0] == '0) && ((bus_addr >> WIN_BITS) == '0);
   assign wr_hit   = bus_wr && in_range;

   evt_timer_cfg #(
      .HALF_W  (DATA_W),
      .WIDE_EN (WIDE_EN)
   ) i_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_load_lo (wr_hit && sel == RG_LOAD_LO),
      .wr_load_hi (wr_hit && sel == RG_LOAD_HI),
      .wr_ctrl    (wr_hit && sel == RG_CTRL),
      .wr_irq     (wr_hit && sel == RG_IRQ),
      .wdata      (bus_wdata),
      .expire     (expire),
      .hw_stop    (hw_stop),
      .load_val   (load_val),
      .ctl_per    (ctl_per),
      .ctl_run    (ctl_run),
      .ctl_wide   (ctl_wide),
      .start      (start),
      .start_wide (start_wide),
      .irq_en     (irq_en),
      .irq_raw    (irq_raw)
   );

   evt_timer_counter #(
      .HALF_W  (DATA_W),
      .WIDE_EN (WIDE_EN)
   ) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wide (start_wide),
      .run        (ctl_run),
      .periodic   (ctl_per),
      .wide       (ctl_wide),
      .load_val   (load_val),
      .cnt        (live_cnt),
      .expire     (expire),
      .hw_stop    (hw_stop)
   );

   evt_timer_shadow #(
      .HALF_W (DATA_W)
   ) i_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (live_cnt),
      .latch_hi (bus_rd && in_range && sel == RG_SHD_LO),
      .shd      (shd_cnt),
      .hi_held  (shd_hi_held)
   );

   assign irq = irq_raw && irq_en;

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         unique case (sel)
            RG_LOAD_LO: bus_rdata = load_val[DATA_W-1:0];
            RG_LOAD_HI: bus_rdata = load_val[CNT_W-1:DATA_W];
            RG_CNT_LO:  bus_rdata = live_cnt[DATA_W-1:0];
            RG_CNT_HI:  bus_rdata = live_cnt[CNT_W-1:DATA_W];
            RG_CTRL: begin
               bus_rdata[CTL_PERIODIC_BIT] = ctl_per;
               bus_rdata[CTL_RUN_BIT]      = ctl_run;
               bus_rdata[CTL_WIDE_BIT]     = ctl_wide;
            end
            RG_IRQ: begin
               bus_rdata[IRQ_EN_BIT]  = irq_en;
               bus_rdata[IRQ_RAW_BIT] = irq_raw;
               bus_rdata[IRQ_MSK_BIT] = irq;
            end
            RG_SHD_LO:  bus_rdata = shd_cnt[DATA_W-1:0];
            RG_SHD_HI:  bus_rdata = shd_hi_held;
            default:    bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              clr_bit,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  load_val,
   input logic [CNT_W-1:0]  shd,
   input logic              run,
   input logic              periodic,
   input logic              wide,
   input logic              start,
   input logic              expire,
   input logic              irq_raw
);

   logic ctl_wr;
   logic clr_wr;

   assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(8'h10));
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(8'h14)) && clr_bit;

   // R3: starting takes the load value
   assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt[HALF_W-1:0] == $past(load_val[HALF_W-1:0]));

   // R3: one step down per clock while the low word is nonzero
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt[HALF_W-1:0] != '0) |=> cnt[HALF_W-1:0] == $past(cnt[HALF_W-1:0]) - 1'b1);

   // R4: expiry sets the raw flag
   assert_raw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq_raw);

   // R4: only a clear write drops the raw flag
   assert_raw_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw && !clr_wr) |=> irq_raw);

   // R5: the line never fires without a pending flag
   assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_raw);

   // R6: one-shot stops at zero
   assert_oneshot_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic && !ctl_wr) |=> (!run && cnt == '0));

   // R9: narrow mode keeps the upper count clear
   assert_narrow_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wide) |=> cnt[CNT_W-1:HALF_W] == '0);

   // R11: the shadow trails the live count by one clock
   assert_shadow_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> shd == $past(cnt));

endmodule

bind evt_timer evt_timer_chk #(
   .HALF_W (DATA_W),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .clr_bit  (bus_wdata[3]),
   .irq      (irq),
   .cnt      (live_cnt),
   .load_val (load_val),
   .shd      (shd_cnt),
   .run      (ctl_run),
   .periodic (ctl_per),
   .wide     (ctl_wide),
   .start    (start),
   .expire   (expire),
   .irq_raw  (irq_raw)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;

   localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_CLO = 5'h08, A_CHI = 5'h0C;
   localparam logic [4:0] A_CTL = 5'h10, A_IRQ = 5'h14, A_SLO = 5'h18, A_SHI = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   // bench model state, stepped per clock from the requirements
   logic [63:0] m_cnt = '0, m_load = '0, m_shd = '0;
   logic [31:0] m_hold = '0;
   logic        m_run = 0, m_per = 0, m_wide = 0, m_raw = 0, m_ie = 0;

   always #2.5 clk = ~clk;

   evt_timer i_evt_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [63:0] wmask(input logic w);
      return w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
   endfunction

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      logic [31:0] v;
      v = '0;
      if (a[1:0] == 2'b00) begin
         case (a[4:2])
            3'd0: v = m_load[31:0];
            3'd1: v = m_load[63:32];
            3'd2: v = m_cnt[31:0];
            3'd3: v = m_cnt[63:32];
            3'd4: begin v[0] = m_per; v[1] = m_run; v[16] = m_wide; end
            3'd5: begin v[0] = m_ie; v[1] = m_raw; v[2] = m_raw & m_ie; end
            3'd6: v = m_shd[31:0];
            default: v = m_hold;
         endcase
      end
      return v;
   endfunction

   task automatic model_step(input logic w, input logic r, input logic [4:0] a, input logic [31:0] d);
      logic hit, wr_ctl, wr_irq, start, ex;
      logic [63:0] cur, nxt;
      hit    = (a[1:0] == 2'b00);
      wr_ctl = w && hit && a[4:2] == 3'd4;
      wr_irq = w && hit && a[4:2] == 3'd5;
      start  = wr_ctl && d[1] && !m_run;
      cur    = m_cnt & wmask(m_wide);
      if (cur == 0) nxt = m_per ? (m_load & wmask(m_wide)) : 64'd0;
      else          nxt = (cur - 64'd1) & wmask(m_wide);
      ex = m_run && nxt == 0;
      if (r && hit && a[4:2] == 3'd6) m_hold = m_shd[63:32];
      m_shd = m_cnt;
      if (start)      m_cnt = m_load & wmask(d[16]);
      else if (m_run) m_cnt = nxt;
      if (ex) m_raw = 1'b1;
      else if (wr_irq && d[3]) m_raw = 1'b0;
      if (wr_irq) m_ie = d[0];
      if (wr_ctl) begin
         m_per = d[0]; m_run = d[1]; m_wide = d[16];
      end else if (ex && !m_per) begin
         m_run = 1'b0;
      end
      if (w && hit && a[4:2] == 3'd0) m_load[31:0]  = d;
      if (w && hit && a[4:2] == 3'd1) m_load[63:32] = d;
   endtask

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // one bus cycle, started at a falling edge
   task automatic cyc(input logic w, input logic r, input logic [4:0] a,
                      input logic [31:0] d, input logic chk, input string tag);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      #1;
      if (chk) begin
         check(tag, {32'd0, bus_rdata}, {32'd0, exp_read(a)});
         check("R5 irq", {63'd0, irq}, {63'd0, m_raw & m_ie});
      end
      @(posedge clk);
      model_step(w, r, a, d);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b0, a, d, 1'b0, "");
   endtask

   task automatic watch(input logic [4:0] a, input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, '0, 1'b1, tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 5'(i * 4), '0, 1'b1, "R1");
      check("R1 irq low", {63'd0, irq}, 64'd0);

      // R2 map and readback
      wr(A_LLO, 32'h1234_5678);
      wr(A_LHI, 32'h9ABC_DEF0);
      watch(A_LLO, 1, "R2");
      watch(A_LHI, 1, "R2");
      wr(A_CTL, 32'hFFFF_FFFD);
      #1 check("R2 ctrl bits", {32'd0, bus_rdata}, 64'h0001_0001);
      watch(A_CTL, 1, "R2");
      wr(A_CTL, 32'h0);

      // R9 narrow periodic, R7 reload
      wr(A_LLO, 32'd3);
      wr(A_LHI, 32'd5);
      wr(A_CTL, 32'h3);
      watch(A_CHI, 6, "R9");
      watch(A_CLO, 10, "R7");
      wr(A_CTL, 32'h0);

      // R4 / R5 flag handling
      watch(A_IRQ, 1, "R4");
      wr(A_IRQ, 32'h1);
      watch(A_IRQ, 1, "R5");
      wr(A_IRQ, 32'h9);
      watch(A_IRQ, 1, "R4");
      wr(A_IRQ, 32'h3);
      watch(A_IRQ, 1, "R4");
      wr(A_IRQ, 32'h0);

      // R3 / R6 one-shot
      wr(A_LLO, 32'd4);
      wr(A_CTL, 32'h2);
      watch(A_CLO, 4, "R3");
      watch(A_CLO, 4, "R6");
      watch(A_CTL, 1, "R6");
      watch(A_IRQ, 1, "R6");

      // R8 load write while running
      wr(A_IRQ, 32'h8);
      wr(A_LLO, 32'd6);
      wr(A_CTL, 32'h3);
      watch(A_CLO, 2, "R8");
      wr(A_LLO, 32'd2);
      watch(A_CLO, 14, "R8");
      wr(A_CTL, 32'h0);

      // R7 load of zero expires every clock
      wr(A_LLO, 32'd0);
      wr(A_CTL, 32'h3);
      wr(A_IRQ, 32'h8);
      watch(A_IRQ, 1, "R7");
      wr(A_CTL, 32'h0);

      // R10 wide borrow
      wr(A_LHI, 32'd1);
      wr(A_LLO, 32'd1);
      wr(A_CTL, 32'h0001_0002);
      watch(A_CLO, 3, "R10");
      watch(A_CHI, 2, "R10");
      wr(A_CTL, 32'h0);

      // R11 coherent shadow pair
      wr(A_LHI, 32'd1);
      wr(A_LLO, 32'd0);
      wr(A_CTL, 32'h0001_0002);
      cyc(1'b0, 1'b0, A_CLO, '0, 1'b0, "");
      cyc(1'b0, 1'b1, A_SLO, '0, 1'b1, "R11");
      bus_addr = A_SHI;
      #1 check("R11 held high", {32'd0, bus_rdata}, 64'd1);
      watch(A_SHI, 1, "R11");
      bus_addr = A_CHI;
      #1 check("R11 live high moved on", {32'd0, bus_rdata}, 64'd0);
      wr(A_CTL, 32'h0);

      // constrained random mix, R7 model compare
      for (int k = 0; k < 600; k++) begin
         int op;
         op = int'($urandom % 10);
         case (op)
            0: wr(A_CTL, {15'd0, 1'($urandom), 14'd0, 2'($urandom)});
            1: wr(A_LLO, $urandom % 24);
            2: wr(A_LHI, $urandom % 2);
            3: wr(A_IRQ, $urandom % 16);
            default: cyc(1'b0, 1'($urandom), 5'(($urandom % 8) * 4), '0, 1'b1, "R7 random");
         endcase
      end

      summary();
      $finish;
   end

endmodule